// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives the five status flags of an 8-bit accumulator operation and keeps them in a register. Each cycle it sees the two operands, the kind of operation (addition, subtraction or a logical operation) and the result that the datapath produced. When the update strobe is high it captures carry, nibble carry, parity, zero and sign at the next rising clock edge. Without the strobe the stored flags are held.

The stored flags are always visible as one packed flag byte. The same byte can be written as a whole, which loads all five flags in one cycle. Software uses this to save and restore the flags.

Top module: `alu_flag_unit`

## Requirements
- R1: For addition (kind 2'b00), the carry flag (packed bit 0) is 1 exactly when op_a_i + op_b_i, taken as unsigned values, exceeds 8 bits.
- R2: For addition, the nibble carry flag (packed bit 4) is 1 exactly when op_a_i[3:0] + op_b_i[3:0] exceeds 4 bits.
- R3: For subtraction (kind 2'b01), the carry flag means borrow: it is 1 when op_b_i > op_a_i as unsigned values. The nibble carry flag is 1 when op_b_i[3:0] > op_a_i[3:0].
- R4: The zero flag (packed bit 6) is 1 exactly when result_i equals 0.
- R5: The sign flag (packed bit 7) copies result_i[7].
- R6: The parity flag (packed bit 2) is 1 when result_i has an even number of one bits and 0 when that number is odd.
- R7: For the logical kinds (2'b10 and 2'b11), the carry and nibble carry flags are cleared, whatever the operands.
- R8: A write (wr_en_i high) loads sign, zero, nibble carry, parity and carry from wr_flags_i bits 7, 6, 4, 2 and 0 at the next rising edge. A write takes priority over a simultaneous update.
- R9: In flags_o, bits 5 and 3 always read 0 and bit 1 always reads 1.
- R10: When neither upd_i nor wr_en_i is high at a rising edge, flags_o does not change.
- R11: A low rst_ni clears all five flags at once, so flags_o reads 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 8 | First operand (minuend for subtraction) |
| op_b_i | input | 8 | Second operand (subtrahend for subtraction) |
| op_kind_i | input | 2 | 00 add, 01 subtract, 10/11 logical |
| result_i | input | 8 | Result produced by the datapath |
| upd_i | input | 1 | Capture the computed flags at the next edge |
| wr_en_i | input | 1 | Load the flags from wr_flags_i at the next edge |
| wr_flags_i | input | 8 | Packed flag byte to load |
| flags_o | output | 8 | Packed flag byte: S, Z, 0, AC, 0, P, 1, CY from bit 7 to bit 0 |

## Verification
The hardest cases to reach are the ones where the result bits and the carries give opposite answers. One is a sum that wraps to zero, which must set zero, parity and both carries together. Another is a logical kind applied to operands that would carry, where the carries must stay clear. The vector table sets these up on purpose: 0xFF+0x01, 0x88 with 0x88 under a logical kind, and 0x00-0x01. A directed sequence then raises the write and the update in the same cycle with conflicting data to show which one wins. It also pulls reset in the middle of the run while the flags are set.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [1:0] {
    KIND_ADD   = 2'b00,
    KIND_SUB   = 2'b01,
    KIND_LOG_A = 2'b10,
    KIND_LOG_B = 2'b11
  } op_kind_e;

  typedef struct packed {
    logic sgn;
    logic zro;
    logic nib;
    logic par;
    logic cy;
  } flags_t;

  // packed byte positions
  localparam int unsigned POS_SGN = 7;
  localparam int unsigned POS_ZRO = 6;
  localparam int unsigned POS_NIB = 4;
  localparam int unsigned POS_PAR = 2;
  localparam int unsigned POS_ONE = 1;
  localparam int unsigned POS_CY  = 0;

  function automatic logic [7:0] pack_flags(flags_t f);
    logic [7:0] b;
    b = 8'h00;
    b[POS_SGN] = f.sgn;
    b[POS_ZRO] = f.zro;
    b[POS_NIB] = f.nib;
    b[POS_PAR] = f.par;
    b[POS_ONE] = 1'b1;
    b[POS_CY]  = f.cy;
    return b;
  endfunction

  function automatic flags_t unpack_flags(logic [7:0] b);
    flags_t f;
    f.sgn = b[POS_SGN];
    f.zro = b[POS_ZRO];
    f.nib = b[POS_NIB];
    f.par = b[POS_PAR];
    f.cy  = b[POS_CY];
    return f;
  endfunction

endpackage

// File: rtl/flag_carry_calc.sv
module flag_carry_calc
  import alu_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  op_kind_e          kind_i,
  output logic              cy_o,
  output logic              nib_o
);

  logic [DATA_W:0] sum_full;
  logic [NIB_W:0]  sum_nib;
  logic            brw_full;
  logic            brw_nib;

  always_comb begin
    sum_full = {1'b0, op_a_i} + {1'b0, op_b_i};
    sum_nib  = {1'b0, op_a_i[NIB_W-1:0]} + {1'b0, op_b_i[NIB_W-1:0]};
    brw_full = op_b_i > op_a_i;
    brw_nib  = op_b_i[NIB_W-1:0] > op_a_i[NIB_W-1:0];
  end

  always_comb begin
    unique case (kind_i)
      KIND_ADD: begin
        cy_o  = sum_full[DATA_W];
        nib_o = sum_nib[NIB_W];
      end
      KIND_SUB: begin
        cy_o  = brw_full;
        nib_o = brw_nib;
      end
      default: begin
        cy_o  = 1'b0;
        nib_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flag_result_calc.sv
module flag_result_calc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  output logic              sgn_o,
  output logic              zro_o,
  output logic              par_o
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic par_lo, par_hi;

  // split parity tree into two halves to shorten depth
  generate
    if (DATA_W >= 4 && (DATA_W % 2 == 0)) begin : g_split
      assign par_lo = ^result_i[HALF_W-1:0];
      assign par_hi = ^result_i[DATA_W-1:HALF_W];
    end else begin : g_flat
      assign par_lo = ^result_i;
      assign par_hi = 1'b0;
    end
  endgenerate

  assign par_o = ~(par_lo ^ par_hi);
  assign zro_o = (result_i == '0);
  assign sgn_o = result_i[DATA_W-1];

endmodule

// File: rtl/flag_store.sv
module flag_store
  import alu_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t calc_i,
  input  logic   wr_en_i,
  input  flags_t wr_i,
  output flags_t flags_o
);

  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (wr_en_i) q <= wr_i;
    else if (upd_i)   q <= calc_i;
  end

  assign flags_o = q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_en_i) |=> $stable(q));

  assert_wr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && upd_i) |=> (q == $past(wr_i)));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        op_kind_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              upd_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_flags_i,
  output logic [7:0]        flags_o
);

  op_kind_e kind;
  flags_t   calc;
  flags_t   wr_f;
  flags_t   cur;

  assign kind = op_kind_e'(op_kind_i);
  assign wr_f = unpack_flags(wr_flags_i);

  flag_carry_calc #(.DATA_W(DATA_W), .NIB_W(NIB_W)) carry_i (
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .kind_i (kind),
    .cy_o   (calc.cy),
    .nib_o  (calc.nib)
  );

  flag_result_calc #(.DATA_W(DATA_W)) result_calc_i (
    .result_i (result_i),
    .sgn_o    (calc.sgn),
    .zro_o    (calc.zro),
    .par_o    (calc.par)
  );

  flag_store store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd_i),
    .calc_i  (calc),
    .wr_en_i (wr_en_i),
    .wr_i    (wr_f),
    .flags_o (cur)
  );

  assign flags_o = pack_flags(cur);

  assert_fixed_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b1));

  assert_logic_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i && op_kind_i[1]) |=> (flags_o[0] == 1'b0 && flags_o[4] == 1'b0));

  assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i) |=> (flags_o[6] == ($past(result_i) == '0)));

  assert_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i) |=> (flags_o[7] == $past(result_i[DATA_W-1])));

  assert_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((flags_o & 8'hD5) == ($past(wr_flags_i) & 8'hD5)));

endmodule

// File: tb/alu_flag_unit_tb_top.sv
module alu_flag_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0, res = '0, wdat = '0;
  logic [1:0] kind = '0;
  logic       upd = 1'b0, wen = 1'b0;
  logic [7:0] flags;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b), .op_kind_i(kind),
    .result_i(res), .upd_i(upd), .wr_en_i(wen), .wr_flags_i(wdat), .flags_o(flags)
  );

  // {kind, a, b, result, expected packed byte}
  localparam logic [33:0] VEC [12] = '{
    {2'b00, 8'hC0, 8'h80, 8'h40, 8'h03},  // R1 carry out
    {2'b00, 8'h04, 8'h05, 8'h09, 8'h06},  // R2 no nibble carry, R6 even
    {2'b00, 8'h08, 8'h08, 8'h10, 8'h12},  // R2 nibble carry
    {2'b00, 8'hFF, 8'h01, 8'h00, 8'h57},  // R1 R2 R4 wrap to zero
    {2'b00, 8'h7F, 8'h01, 8'h80, 8'h92},  // R5 sign
    {2'b01, 8'h05, 8'h07, 8'hFE, 8'h93},  // R3 borrow
    {2'b01, 8'h10, 8'h01, 8'h0F, 8'h16},  // R3 nibble borrow only
    {2'b01, 8'h33, 8'h33, 8'h00, 8'h46},  // R3 equal, R4
    {2'b10, 8'hFF, 8'h81, 8'h81, 8'h86},  // R7 logical
    {2'b11, 8'h88, 8'h88, 8'h07, 8'h02},  // R7 carries suppressed, R6 odd
    {2'b00, 8'h88, 8'h88, 8'h10, 8'h13},  // R1 R2 both carries
    {2'b01, 8'h00, 8'h01, 8'hFF, 8'h97}   // R3 R6 R5
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (flags !== exp) begin
      n_err++;
      $display("FAIL %s: flags=%02h expected=%02h", req, flags, exp);
    end
  endtask

  task automatic step_update(input logic [1:0] k, input logic [7:0] x, input logic [7:0] y,
                             input logic [7:0] r);
    @(negedge clk);
    kind = k; a = x; b = y; res = r; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", 8'h02);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", 8'h02);

    foreach (VEC[i]) begin
      step_update(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
      check($sformatf("R1-R7 vector %0d (R1 R2 R3 R4 R5 R6 R7)", i), VEC[i][7:0]);
    end

    // R10: inputs change without strobe
    @(negedge clk);
    kind = 2'b00; a = 8'hFF; b = 8'hFF; res = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 hold", 8'h97);

    // R8 R9: packed write of all ones, then all zeros
    wdat = 8'hFF; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
    check("R8 R9 write ones", 8'hD7);
    wdat = 8'h28; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
    check("R8 R9 write reserved only", 8'h02);

    // R8: write wins over update
    kind = 2'b00; a = 8'hFF; b = 8'h01; res = 8'h00;
    wdat = 8'h81; wen = 1'b1; upd = 1'b1;
    @(negedge clk);
    wen = 1'b0; upd = 1'b0;
    check("R8 write priority", 8'h83);

    // R11: reset in mid run
    step_update(2'b00, 8'hFF, 8'h01, 8'h00);
    check("R4 before reset", 8'h57);
    #2 rst_n = 1'b0;
    #1 check("R11 async reset", 8'h02);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 held after reset", 8'h02);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

endmodule